// File: doc/BRIEF.md
# Pausable Sample Clock Generator with Convert Burst

This block creates the sample clock of an acquisition engine. In divider mode it counts strobes from one of five timebases (two fast internal strobes, one slow internal strobe, and the synchronized rising edges of an external pin or of a comparator event) and emits one single-cycle sample pulse every N counted strobes. In the two direct modes it skips the divider and turns each rising edge of an external clock pin, or of an on-chip counter output, into one sample pulse.

A pause input gates the pulse stream. It reacts only to level. Its source is either a dedicated pin or the comparator event, and its active level is programmable. While the input is at its active level, no sample pulse is produced. The divider keeps its count, so the phase carries on after the pause ends.

Each accepted sample pulse starts a burst of convert pulses, one per scanned channel, at a programmable spacing, to drive a multiplexed converter. A busy flag covers the whole burst. A sample pulse that arrives during a burst is dropped and sets a sticky overrun flag. Configuration may change only while the enable input is low.

Top module: `smpclk_gen`

## Requirements
- R1: After reset, and in every cycle that follows a cycle with `en` low, `smp_out` equals `cfg_smp_inv`, `conv_out` is 0 and `busy` is 0. After reset `overrun` is 0. Pins synchronize through two flops that reset to 0.
- R2: When `cfg_src_mode`=0 (divider), `cfg_tb_sel` picks the counted strobe: 0 fast A, 1 fast B, 2 slow, 3 rising edge of `ext_tb_pin`, 4 rising edge of `cmp_evt_in`. Codes 5 to 7 count nothing. A pin edge counts in the third cycle after the pin is first driven high. One sample pulse is produced in the cycle after every `cfg_divisor`-th counted strobe. A divisor below 2 acts as 2.
- R3: `cfg_src_mode`=1 gives one pulse per synchronized rising edge of `ext_clk_pin`, in the third cycle after the pin is first driven high. `cfg_src_mode`=2 gives one pulse in the cycle after `ctr_out_in` first goes high. This input is not synchronized. `cfg_src_mode`=3 gives no pulses.
- R4: The pause level is the synchronized `pause_pin` when `cfg_pause_src`=0 and the synchronized `cmp_evt_in` when it is 1. While that level equals `cfg_pause_pol`, no sample pulse is produced.
- R5: Strobes that arrive while paused are not counted, and the divider keeps its count. The first pulse after a pause comes after the strobes still missing from the interrupted period.
- R6: `smp_out` is the sample pulse XOR `cfg_smp_inv`. It is active high when the bit is 0.
- R7: An accepted sample pulse in cycle s yields `cfg_chan_cnt`+1 convert pulses (1 to 16), one cycle wide, in cycles s+1+k·G, where G is `cfg_conv_gap` and 0 acts as 1.
- R8: `busy` is high from the sample-pulse cycle through the cycle of the last convert pulse, and low otherwise.
- R9: A sample pulse in a cycle where a burst started earlier is still running (up to and including its last convert cycle) starts no burst and sets `overrun` from the next cycle on. `ovr_clr` clears it in the next cycle, and a new drop in the same cycle wins over the clear.
- R10: Driving `en` low stops a running burst and clears the divider from the next cycle on. `overrun` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Run enable; low clears divider and burst |
| tb_fast_a_stb | input | 1 | Fast timebase A strobe |
| tb_fast_b_stb | input | 1 | Fast timebase B strobe |
| tb_slow_stb | input | 1 | Slow timebase strobe |
| ext_tb_pin | input | 1 | Asynchronous external timebase pin |
| cmp_evt_in | input | 1 | Asynchronous comparator event |
| ext_clk_pin | input | 1 | Asynchronous direct sample clock pin |
| ctr_out_in | input | 1 | On-chip counter output, same clock domain |
| pause_pin | input | 1 | Asynchronous pause pin |
| cfg_src_mode | input | 2 | Sample source: divider, pin, counter, none |
| cfg_tb_sel | input | 3 | Timebase code for divider mode |
| cfg_divisor | input | DIV_W | Strobes per sample pulse |
| cfg_pause_src | input | 1 | Pause source: pin (0) or comparator (1) |
| cfg_pause_pol | input | 1 | Pause active level |
| cfg_smp_inv | input | 1 | Invert the sample output |
| cfg_chan_cnt | input | CHAN_W | Channels per burst minus one |
| cfg_conv_gap | input | GAP_W | Clocks between convert pulses |
| ovr_clr | input | 1 | Clear the overrun flag |
| smp_out | output | 1 | Sample pulse |
| conv_out | output | 1 | Convert pulse |
| busy | output | 1 | Burst in progress |
| overrun | output | 1 | Sticky dropped-sample flag |

## Verification
A divider count that is wrong, or that drifts during a pause, moves the next sample pulse off its expected cycle. A cycle-exact comparison of `smp_out` catches it at the first pulse that follows. A sequencer with a wrong remaining count or spacing shows as a `conv_out` pulse in the wrong cycle, or a `busy` that ends early or late, within the same burst. A stale active state shows as a missed or spurious `overrun` at the next sample pulse that overlaps a burst.

// File: rtl/smpclk_pkg.sv
package smpclk_pkg;

    typedef enum logic [1:0] {
        SRC_DIVIDER = 2'd0,
        SRC_EXT_CLK = 2'd1,
        SRC_COUNTER = 2'd2,
        SRC_NONE    = 2'd3
    } smp_src_e;

    typedef enum logic [2:0] {
        TB_FAST_A  = 3'd0,
        TB_FAST_B  = 3'd1,
        TB_SLOW    = 3'd2,
        TB_EXT_PIN = 3'd3,
        TB_CMP     = 3'd4
    } tb_sel_e;

    // Asynchronous sources handled by the synchronizer bank
    typedef struct packed {
        logic pause_pin;
        logic ext_clk;
        logic cmp;
        logic ext_tb;
    } async_bus_t;

    typedef struct packed {
        logic fast_a;
        logic fast_b;
        logic slow;
    } tb_strobe_t;

    typedef struct packed {
        smp_src_e src;
        tb_sel_e  tb;
        logic     pause_src;   // 0: pause pin, 1: comparator
        logic     pause_pol;   // level that pauses
    } mode_cfg_t;

    localparam int unsigned SYNC_STAGES = 2;

    function automatic logic pause_active(input mode_cfg_t m, input async_bus_t lvl);
        logic l;
        l = m.pause_src ? lvl.cmp : lvl.pause_pin;
        return l == m.pause_pol;
    endfunction

endpackage

// File: rtl/smpclk_sync.sv
module smpclk_sync
    import smpclk_pkg::*;
#(
    parameter int STAGES = SYNC_STAGES
) (
    input  logic       clk,
    input  logic       rst,
    input  async_bus_t async_in,
    output async_bus_t lvl,
    output async_bus_t rise
);
    localparam int NB = $bits(async_bus_t);

    logic [STAGES-1:0][NB-1:0] pipe;
    logic [NB-1:0]             last;
    logic [NB-1:0]             rise_bits;

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe <= '0;
            last <= '0;
        end else begin
            pipe <= {pipe[STAGES-2:0], async_in};
            last <= pipe[STAGES-1];
        end
    end

    for (genvar b = 0; b < NB; b++) begin : g_edge
        assign rise_bits[b] = pipe[STAGES-1][b] & ~last[b];
    end

    assign lvl  = async_bus_t'(pipe[STAGES-1]);
    assign rise = async_bus_t'(rise_bits);

endmodule

// File: rtl/smpclk_divider.sv
module smpclk_divider
    import smpclk_pkg::*;
#(
    parameter int DIV_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  mode_cfg_t        mode,
    input  logic [DIV_W-1:0] divisor,
    input  tb_strobe_t       stb,
    input  logic             ctr_in,
    input  async_bus_t       lvl,
    input  async_bus_t       rise,
    output logic             smp_pulse
);
    logic [DIV_W-1:0] div_n;
    logic [DIV_W-1:0] cnt;
    logic             tick;
    logic             paused;
    logic             ctr_prev;
    logic             ctr_rise;
    logic             direct_ev;

    assign div_n    = (divisor < DIV_W'(2)) ? DIV_W'(2) : divisor;
    assign paused   = pause_active(mode, lvl);
    assign ctr_rise = ctr_in & ~ctr_prev;

    always_comb begin
        case (mode.tb)
            TB_FAST_A:  tick = stb.fast_a;
            TB_FAST_B:  tick = stb.fast_b;
            TB_SLOW:    tick = stb.slow;
            TB_EXT_PIN: tick = rise.ext_tb;
            TB_CMP:     tick = rise.cmp;
            default:    tick = 1'b0;
        endcase
    end

    always_comb begin
        case (mode.src)
            SRC_EXT_CLK: direct_ev = rise.ext_clk;
            SRC_COUNTER: direct_ev = ctr_rise;
            default:     direct_ev = 1'b0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) ctr_prev <= 1'b0;
        else     ctr_prev <= ctr_in;
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            cnt       <= '0;
            smp_pulse <= 1'b0;
        end else begin
            smp_pulse <= 1'b0;
            if (!paused) begin
                if (mode.src == SRC_DIVIDER) begin
                    if (tick) begin
                        if (cnt == div_n - DIV_W'(1)) begin
                            cnt       <= '0;
                            smp_pulse <= 1'b1;
                        end else begin
                            cnt <= cnt + DIV_W'(1);
                        end
                    end
                end else begin
                    smp_pulse <= direct_ev;
                end
            end
        end
    end

    p_cnt_range_r2: assert property (@(posedge clk) disable iff (rst || !en)
        cnt < div_n);

    p_single_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        smp_pulse |=> !smp_pulse);

    p_paused_quiet_r4: assert property (@(posedge clk) disable iff (rst)
        (en && paused) |=> !smp_pulse);

    p_pause_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (en && paused) |=> (cnt == $past(cnt)));

endmodule

// File: rtl/smpclk_conv_seq.sv
module smpclk_conv_seq #(
    parameter int CHAN_W = 4,
    parameter int GAP_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              smp_pulse,
    input  logic [CHAN_W-1:0] chan_field,
    input  logic [GAP_W-1:0]  gap,
    input  logic              ovr_clr,
    output logic              conv_out,
    output logic              busy,
    output logic              overrun
);
    logic [GAP_W-1:0]  gap_eff;
    logic [GAP_W-1:0]  gcnt;
    logic [CHAN_W-1:0] left;
    logic              active;
    logic              conv_q;
    logic              ovr_q;
    logic              accept;
    logic              drop;

    assign gap_eff = (gap == '0) ? GAP_W'(1) : gap;
    assign accept  = en & smp_pulse & ~active;
    assign drop    = en & smp_pulse & active;

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            active <= 1'b0;
            conv_q <= 1'b0;
            left   <= '0;
            gcnt   <= '0;
        end else if (accept) begin
            active <= 1'b1;
            conv_q <= 1'b1;
            left   <= chan_field;
            gcnt   <= gap_eff;
        end else if (active) begin
            if (conv_q && left == '0) begin
                active <= 1'b0;
                conv_q <= 1'b0;
            end else if (gcnt == GAP_W'(1)) begin
                conv_q <= 1'b1;
                left   <= left - CHAN_W'(1);
                gcnt   <= gap_eff;
            end else begin
                conv_q <= 1'b0;
                gcnt   <= gcnt - GAP_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst)          ovr_q <= 1'b0;
        else if (drop)    ovr_q <= 1'b1;
        else if (ovr_clr) ovr_q <= 1'b0;
    end

    assign conv_out = conv_q;
    assign busy     = active | smp_pulse;
    assign overrun  = ovr_q;

    p_conv_spacing_r7: assert property (@(posedge clk) disable iff (rst || !en)
        (conv_q && gap_eff > GAP_W'(1)) |=> !conv_q);

    p_drop_flags_r9: assert property (@(posedge clk) disable iff (rst)
        (en && smp_pulse && active) |=> overrun);

    p_ovr_sticky_r9: assert property (@(posedge clk) disable iff (rst)
        (overrun && !ovr_clr) |=> overrun);

    p_disable_stops_r10: assert property (@(posedge clk) disable iff (rst)
        !en |=> (!active && !conv_q));

endmodule

// File: rtl/smpclk_gen.sv
module smpclk_gen
    import smpclk_pkg::*;
#(
    parameter int DIV_W  = 16,
    parameter int CHAN_W = 4,
    parameter int GAP_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic              tb_fast_a_stb,
    input  logic              tb_fast_b_stb,
    input  logic              tb_slow_stb,
    input  logic              ext_tb_pin,
    input  logic              cmp_evt_in,
    input  logic              ext_clk_pin,
    input  logic              ctr_out_in,
    input  logic              pause_pin,
    input  logic [1:0]        cfg_src_mode,
    input  logic [2:0]        cfg_tb_sel,
    input  logic [DIV_W-1:0]  cfg_divisor,
    input  logic              cfg_pause_src,
    input  logic              cfg_pause_pol,
    input  logic              cfg_smp_inv,
    input  logic [CHAN_W-1:0] cfg_chan_cnt,
    input  logic [GAP_W-1:0]  cfg_conv_gap,
    input  logic              ovr_clr,
    output logic              smp_out,
    output logic              conv_out,
    output logic              busy,
    output logic              overrun
);
    async_bus_t async_in;
    async_bus_t sync_lvl;
    async_bus_t sync_rise;
    tb_strobe_t stb;
    mode_cfg_t  mode;
    logic       smp_pulse;

    assign async_in = '{pause_pin: pause_pin, ext_clk: ext_clk_pin,
                        cmp: cmp_evt_in, ext_tb: ext_tb_pin};
    assign stb      = '{fast_a: tb_fast_a_stb, fast_b: tb_fast_b_stb,
                        slow: tb_slow_stb};
    assign mode     = '{src: smp_src_e'(cfg_src_mode), tb: tb_sel_e'(cfg_tb_sel),
                        pause_src: cfg_pause_src, pause_pol: cfg_pause_pol};

    smpclk_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst      (rst),
        .async_in (async_in),
        .lvl      (sync_lvl),
        .rise     (sync_rise)
    );

    smpclk_divider #(.DIV_W(DIV_W)) u_div (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .mode      (mode),
        .divisor   (cfg_divisor),
        .stb       (stb),
        .ctr_in    (ctr_out_in),
        .lvl       (sync_lvl),
        .rise      (sync_rise),
        .smp_pulse (smp_pulse)
    );

    smpclk_conv_seq #(.CHAN_W(CHAN_W), .GAP_W(GAP_W)) u_seq (
        .clk        (clk),
        .rst        (rst),
        .en         (en),
        .smp_pulse  (smp_pulse),
        .chan_field (cfg_chan_cnt),
        .gap        (cfg_conv_gap),
        .ovr_clr    (ovr_clr),
        .conv_out   (conv_out),
        .busy       (busy),
        .overrun    (overrun)
    );

    assign smp_out = smp_pulse ^ cfg_smp_inv;

    p_conv_in_busy_r8: assert property (@(posedge clk) disable iff (rst)
        conv_out |-> busy);

    p_rst_idle_r1: assert property (@(posedge clk)
        rst |=> (!conv_out && !busy && !overrun));

endmodule

// File: tb/smpclk_gen_tb_top.sv
module smpclk_gen_tb_top;
    localparam int DIV_W  = 16;
    localparam int CHAN_W = 4;
    localparam int GAP_W  = 8;

    logic clk = 1'b0;
    always #2 clk = ~clk;   // 250 MHz

    logic rst = 1'b1, en = 1'b0;
    logic tb_fast_a_stb = 0, tb_fast_b_stb = 0, tb_slow_stb = 0;
    logic ext_tb_pin = 0, cmp_evt_in = 0, ext_clk_pin = 0, ctr_out_in = 0, pause_pin = 0;
    logic [1:0]        cfg_src_mode = 0;
    logic [2:0]        cfg_tb_sel = 0;
    logic [DIV_W-1:0]  cfg_divisor = 2;
    logic              cfg_pause_src = 0, cfg_pause_pol = 1, cfg_smp_inv = 0;
    logic [CHAN_W-1:0] cfg_chan_cnt = 0;
    logic [GAP_W-1:0]  cfg_conv_gap = 1;
    logic              ovr_clr = 0;
    logic smp_out, conv_out, busy, overrun;

    smpclk_gen #(.DIV_W(DIV_W), .CHAN_W(CHAN_W), .GAP_W(GAP_W)) dut_i (
        .clk(clk), .rst(rst), .en(en),
        .tb_fast_a_stb(tb_fast_a_stb), .tb_fast_b_stb(tb_fast_b_stb), .tb_slow_stb(tb_slow_stb),
        .ext_tb_pin(ext_tb_pin), .cmp_evt_in(cmp_evt_in), .ext_clk_pin(ext_clk_pin),
        .ctr_out_in(ctr_out_in), .pause_pin(pause_pin),
        .cfg_src_mode(cfg_src_mode), .cfg_tb_sel(cfg_tb_sel), .cfg_divisor(cfg_divisor),
        .cfg_pause_src(cfg_pause_src), .cfg_pause_pol(cfg_pause_pol), .cfg_smp_inv(cfg_smp_inv),
        .cfg_chan_cnt(cfg_chan_cnt), .cfg_conv_gap(cfg_conv_gap), .ovr_clr(ovr_clr),
        .smp_out(smp_out), .conv_out(conv_out), .busy(busy), .overrun(overrun)
    );

    int    n_tests = 0, n_fail = 0;
    string cur_req = "R1";
    bit    chk_on = 0;
    bit    done = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input int got, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s got %0d expected %0d at %0t", req, what, got, exp, $time);
        end
    endtask

    // ---------------- stimulus generators ----------------
    int r_fa = 0, r_fb = 0, r_sl = 0;
    int t_et = 0, t_cmp = 0, t_ck = 0, t_ctr = 0, t_pz = 0, t_clr = 0;
    bit pz_val = 0, clr_force = 0;

    always @(negedge clk) begin
        #1;
        tb_fast_a_stb = (r_fa != 0) && ($urandom % r_fa == 0);
        tb_fast_b_stb = (r_fb != 0) && ($urandom % r_fb == 0);
        tb_slow_stb   = (r_sl != 0) && ($urandom % r_sl == 0);
        if (t_et  != 0 && $urandom % t_et  == 0) ext_tb_pin  = ~ext_tb_pin;
        if (t_cmp != 0 && $urandom % t_cmp == 0) cmp_evt_in  = ~cmp_evt_in;
        if (t_ck  != 0 && $urandom % t_ck  == 0) ext_clk_pin = ~ext_clk_pin;
        if (t_ctr != 0 && $urandom % t_ctr == 0) ctr_out_in  = ~ctr_out_in;
        if (t_pz != 0) begin
            if ($urandom % t_pz == 0) pause_pin = ~pause_pin;
        end else begin
            pause_pin = pz_val;
        end
        ovr_clr = clr_force || ((t_clr != 0) && ($urandom % t_clr == 0));
    end

    // ---------------- behavioural reference model ----------------
    int m_cyc = 0, m_seen = 0, m_bend = -1;
    int m_conv_at[$];
    bit q_et[$]  = '{0, 0, 0};
    bit q_cmp[$] = '{0, 0, 0};
    bit q_ck[$]  = '{0, 0, 0};
    bit q_pz[$]  = '{0, 0, 0};
    bit m_ctr_prev = 0;
    bit m_smp = 0, m_conv = 0, m_busy = 0, m_ovr = 0;

    always @(posedge clk) begin : model
        int  n_eff, g_eff, c_tot;
        bit  pl, paused, tick, fire, set_ovr, nxt_ovr;
        bit  r_et, r_cmp, r_ck, r_ctr;
        n_eff = (cfg_divisor < 2) ? 2 : int'(cfg_divisor);
        g_eff = (cfg_conv_gap == 0) ? 1 : int'(cfg_conv_gap);
        c_tot = int'(cfg_chan_cnt) + 1;
        // pin values seen by logic this cycle: two cycles old
        pl     = cfg_pause_src ? q_cmp[1] : q_pz[1];
        paused = (pl == cfg_pause_pol);
        r_et   = q_et[1]  && !q_et[0];
        r_cmp  = q_cmp[1] && !q_cmp[0];
        r_ck   = q_ck[1]  && !q_ck[0];
        r_ctr  = ctr_out_in && !m_ctr_prev;
        case (cfg_tb_sel)
            3'd0: tick = tb_fast_a_stb;
            3'd1: tick = tb_fast_b_stb;
            3'd2: tick = tb_slow_stb;
            3'd3: tick = r_et;
            3'd4: tick = r_cmp;
            default: tick = 0;
        endcase
        fire = 0;
        nxt_ovr = m_ovr;
        if (rst) begin
            m_seen = 0; m_bend = -1; m_conv_at.delete(); nxt_ovr = 0;
        end else begin
            if (en) begin
                if (!paused) begin
                    case (cfg_src_mode)
                        2'd0: if (tick) begin
                                  m_seen++;
                                  if (m_seen == n_eff) begin fire = 1; m_seen = 0; end
                              end
                        2'd1: fire = r_ck;
                        2'd2: fire = r_ctr;
                        default: fire = 0;
                    endcase
                end
            end else if (cfg_src_mode == 2'd0) begin
                m_seen = 0;
            end else begin
                m_seen = 0;
            end
            set_ovr = 0;
            if (en && m_smp) begin
                if (m_cyc <= m_bend) set_ovr = 1;
                else begin
                    for (int k = 0; k < c_tot; k++) m_conv_at.push_back(m_cyc + 1 + k * g_eff);
                    m_bend = m_cyc + 1 + (c_tot - 1) * g_eff;
                end
            end
            if (set_ovr) nxt_ovr = 1;
            else if (ovr_clr) nxt_ovr = 0;
            if (!en) begin m_bend = -1; m_conv_at.delete(); end
        end
        m_cyc++;
        m_smp = fire;
        if (m_conv_at.size() > 0 && m_conv_at[0] == m_cyc) begin
            m_conv = 1; void'(m_conv_at.pop_front());
        end else m_conv = 0;
        m_busy = m_smp || (m_cyc <= m_bend);
        m_ovr  = nxt_ovr;
        q_et.push_back(rst ? 1'b0 : ext_tb_pin);   void'(q_et.pop_front());
        q_cmp.push_back(rst ? 1'b0 : cmp_evt_in);  void'(q_cmp.pop_front());
        q_ck.push_back(rst ? 1'b0 : ext_clk_pin);  void'(q_ck.pop_front());
        q_pz.push_back(rst ? 1'b0 : pause_pin);    void'(q_pz.pop_front());
        m_ctr_prev = rst ? 1'b0 : ctr_out_in;
    end

    // per-cycle comparison, R6 covers the output polarity
    always @(negedge clk) begin
        if (chk_on && !done) begin
            check(smp_out === (m_smp ^ cfg_smp_inv), cur_req, "smp_out",
                  int'(smp_out), int'(m_smp ^ cfg_smp_inv));
            check(conv_out === m_conv, "R7", "conv_out", int'(conv_out), int'(m_conv));
            check(busy === m_busy, "R8", "busy", int'(busy), int'(m_busy));
            check(overrun === m_ovr, "R9", "overrun", int'(overrun), int'(m_ovr));
        end
    end

    task automatic step();
        @(negedge clk); #1;
    endtask

    task automatic run_cfg(input string req, input int mode, input int sel, input int div,
                           input bit psrc, input bit ppol, input bit inv,
                           input int chan, input int gap, input int ncyc);
        step(); en = 0; step(); step();
        cur_req = req;
        cfg_src_mode = 2'(mode); cfg_tb_sel = 3'(sel); cfg_divisor = DIV_W'(div);
        cfg_pause_src = psrc; cfg_pause_pol = ppol; cfg_smp_inv = inv;
        cfg_chan_cnt = CHAN_W'(chan); cfg_conv_gap = GAP_W'(gap);
        en = 1;
        repeat (ncyc) step();
    endtask

    task automatic quiet();
        r_fa = 0; r_fb = 0; r_sl = 0; t_et = 0; t_cmp = 0; t_ck = 0; t_ctr = 0;
        t_pz = 0; pz_val = 0; t_clr = 0;
    endtask

    initial begin : main
        int hi;
        repeat (5) step();
        rst = 0;
        @(negedge clk);
        // R1: reset state at the ports
        check(smp_out === 1'b0 && conv_out === 1'b0 && busy === 1'b0 && overrun === 1'b0,
              "R1", "reset outputs", int'({smp_out, conv_out, busy, overrun}), 0);
        #1; chk_on = 1;

        quiet(); r_fa = 1;
        run_cfg("R2", 0, 0, 4, 0, 1, 0, 1, 1, 200);
        quiet(); r_fb = 3;
        run_cfg("R2", 0, 1, 3, 0, 1, 0, 0, 2, 200);
        quiet(); r_sl = 5;
        run_cfg("R2", 0, 2, 2, 0, 1, 0, 2, 3, 300);
        quiet(); t_et = 3;
        run_cfg("R2", 0, 3, 3, 0, 1, 0, 1, 1, 300);
        quiet(); t_cmp = 4;   // divisor 1 acts as 2
        run_cfg("R2", 0, 4, 1, 0, 1, 0, 0, 1, 300);
        quiet(); t_ck = 4;
        run_cfg("R3", 1, 0, 5, 0, 1, 0, 0, 1, 300);
        quiet(); t_ctr = 3;
        run_cfg("R3", 2, 0, 5, 0, 1, 0, 1, 2, 300);
        quiet(); r_fa = 1; t_ctr = 2;   // mode 3 gives nothing
        run_cfg("R3", 3, 0, 2, 0, 1, 0, 0, 1, 100);
        quiet(); r_fa = 2; t_pz = 6;
        run_cfg("R5", 0, 0, 3, 0, 1, 0, 0, 1, 600);
        quiet(); t_ck = 3; t_cmp = 7;
        run_cfg("R4", 1, 0, 2, 1, 0, 0, 0, 1, 500);

        // R4 directed: pause held active, no sample pulse at all
        quiet(); r_fa = 1; pz_val = 1;
        run_cfg("R4", 0, 0, 2, 0, 1, 0, 0, 1, 4);
        hi = 0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (smp_out) hi++;
        end
        check(hi == 0, "R4", "pulses while paused", hi, 0);
        #1; pz_val = 0;
        repeat (30) step();

        quiet(); r_fa = 1;
        run_cfg("R6", 0, 0, 3, 0, 1, 1, 0, 1, 200);
        quiet(); r_fa = 1;
        run_cfg("R7", 0, 0, 40, 0, 1, 0, 15, 1, 400);
        quiet(); r_fa = 1;
        run_cfg("R7", 0, 0, 30, 0, 1, 0, 4, 0, 300);

        // R9: overlapping samples, random clears
        quiet(); r_fa = 1; t_clr = 9;
        run_cfg("R9", 0, 0, 2, 0, 1, 0, 3, 3, 400);
        t_clr = 0;
        repeat (20) step();
        @(negedge clk);
        check(overrun === 1'b1, "R9", "overrun set by drop", int'(overrun), 1);
        // R10: disable mid-flight, overrun kept
        #1; en = 0;
        step(); step();
        @(negedge clk);
        check(conv_out === 1'b0 && busy === 1'b0, "R10", "burst after disable",
              int'({conv_out, busy}), 0);
        check(overrun === 1'b1, "R10", "overrun kept on disable", int'(overrun), 1);
        check(smp_out === cfg_smp_inv, "R1", "idle smp_out while disabled",
              int'(smp_out), int'(cfg_smp_inv));
        #1; clr_force = 1; step(); clr_force = 0;
        @(negedge clk);
        check(overrun === 1'b0, "R9", "overrun cleared", int'(overrun), 0);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_tests++; n_fail++;
            $display("FAIL watchdog expired, run hung: got timeout expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule